// File: doc/BRIEF.md
# Programmable I2S Sample Delay Line

This block sits in a stereo I2S path and adds a second, time-shifted copy of the stream. It runs entirely on the incoming bit clock. The incoming word select and serial data are retimed by one bit clock and sent straight on. A second serial data line carries the same left and right samples, taken from a stereo frame buffer some whole number of frames earlier. The downstream consumer therefore sees four channels on a shared bit clock and word select: left and right direct on data line 0, and left and right delayed on data line 1. The clock is never regenerated or re-driven; downstream logic uses the same bit clock.

The delay is programmed in microseconds. A rate select code tells the block which sample rate is active. The block converts the time setting to a frame count for that rate, so the acoustic delay stays the same whatever the rate. Whenever the derived frame count changes, the delayed line plays silence until enough fresh frames have been stored. This keeps frames captured under the old setting off the output.

Framing is standard I2S. Word select is low for the left channel, and each channel slot is 32 bit clocks long. Data is sent MSB first, starting one bit clock after each word-select transition. Samples are 24 bits, left-justified in the slot.

Top module: `i2s_delay_line`

## Requirements
- R1: While `rst_n` is low, `ws_o`, `sd0_o` and `sd1_o` are all 0, whatever `ws_i` and `sd_i` do.
- R2: The frame count N is round(delay_us × Fs / 1e6), with Fs picked by `rate_sel`: 0 = 44.1 kHz, 1 = 48 kHz, 2 = 88.2 kHz, 3 = 96 kHz, 4 = 176.4 kHz, 5 = 192 kHz. Codes 6 and 7 act as 48 kHz.
- R3: The left word on `sd1_o` in output frame m equals, bit for bit, the 24-bit left word that entered in frame m−N. A frame starts at a falling edge of word select. The word occupies slot bits 1..24, MSB first.
- R4: `ws_o` equals `ws_i` delayed by exactly one bit clock.
- R5: `sd0_o` equals `sd_i` delayed by exactly one bit clock, so the direct pair stays bit-exact and aligned with `ws_o`.
- R6: The right word on `sd1_o` in output frame m (the slot where `ws_o` is high) equals the right word of input frame m−N.
- R7: `sd1_o` is 0 in slot bit 0 and in slot bits 25..31 of every slot.
- R8: After N changes, the delayed line is all zeros in every output frame m where m−N is earlier than the frame in which the change arrived. The frame count counts as changed after reset, too.
- R9: N is clamped to the range 1..64. A setting that rounds to 0 frames gives a delay of one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Incoming I2S bit clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Incoming word select (low = left) |
| sd_i | input | 1 | Incoming serial data |
| rate_sel | input | 3 | Active sample-rate code |
| delay_us | input | 8 | Requested delay in microseconds |
| ws_o | output | 1 | Retimed word select |
| sd0_o | output | 1 | Direct stereo data, line 0 |
| sd1_o | output | 1 | Delayed stereo data, line 1 |

## Verification
Random 24-bit left and right words are streamed through a series of settings. Each setting chooses a different rate code and microsecond value, so distinct frame counts are produced: 2, 10, 48, 44 and 16 frames, one frame from a zero setting, and a fallback rate code. This separates a wrong rounding or rate table from a wrong pointer offset. Each setting change lands mid-frame. The zero frames that follow show whether muting ends after exactly N fresh frames rather than too early or too late. Distinct random left and right words catch any channel swap on the delayed line. Comparing the direct line word for word catches any bit or alignment slip.

// File: rtl/i2s_delay_line.sv
module i2s_delay_line #(
  parameter int DW    = 24,
  parameter int SLOT  = 32,
  parameter int DEPTH = 64,
  parameter int US_W  = 8
) (
  input  logic            bclk_i,
  input  logic            rst_n,
  input  logic            ws_i,
  input  logic            sd_i,
  input  logic [2:0]      rate_sel,
  input  logic [US_W-1:0] delay_us,
  output logic            ws_o,
  output logic            sd0_o,
  output logic            sd1_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(SLOT);
  localparam int NW = AW + 1;

  logic            ws_q;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   sh, lcap, dsh, rhold;
  logic [AW-1:0]   wr_ptr;
  logic [NW-1:0]   frames, frames_q, fill;
  logic [2*DW-1:0] mem [DEPTH];
  logic [2*DW-1:0] rd_word;
  logic [10:0]     fs100;
  logic [31:0]     prod, quo;

  wire wse  = ws_i ^ ws_q;
  wire rise = wse & ws_i;
  wire fall = wse & ~ws_i;
  wire chg  = frames != frames_q;
  wire ok   = fill >= (frames - NW'(1));
  wire [AW-1:0] rd_addr = wr_ptr + AW'(1) - frames[AW-1:0];

  always_comb begin
    case (rate_sel)
      3'd0:    fs100 = 11'd441;
      3'd1:    fs100 = 11'd480;
      3'd2:    fs100 = 11'd882;
      3'd3:    fs100 = 11'd960;
      3'd4:    fs100 = 11'd1764;
      3'd5:    fs100 = 11'd1920;
      default: fs100 = 11'd480;
    endcase
  end

  assign prod   = 32'(delay_us) * 32'(fs100) + 32'd5000;
  assign quo    = prod / 32'd10000;
  assign frames = (quo == 32'd0)        ? NW'(1) :
                  (quo > 32'(DEPTH))    ? NW'(DEPTH) : NW'(quo);

  assign rd_word = (frames == NW'(1)) ? {lcap, sh} : mem[rd_addr];

  always_ff @(posedge bclk_i) begin
    if (rst_n && fall) mem[wr_ptr] <= {lcap, sh};
  end

  always_ff @(posedge bclk_i or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      ws_o     <= 1'b0;
      sd0_o    <= 1'b0;
      sd1_o    <= 1'b0;
      cnt      <= CW'(SLOT-1);
      sh       <= '0;
      lcap     <= '0;
      dsh      <= '0;
      rhold    <= '0;
      wr_ptr   <= '0;
      frames_q <= '0;
      fill     <= '0;
    end else begin
      ws_q     <= ws_i;
      ws_o     <= ws_i;
      sd0_o    <= sd_i;
      frames_q <= frames;

      if (wse) cnt <= '0;
      else if (cnt != CW'(SLOT-1)) cnt <= cnt + CW'(1);

      if (!wse && cnt < CW'(DW)) sh <= {sh[DW-2:0], sd_i};
      if (rise) lcap <= sh;
      if (fall) wr_ptr <= wr_ptr + AW'(1);

      if (chg) fill <= '0;
      else if (fall && fill != NW'(DEPTH)) fill <= fill + NW'(1);

      if (chg) begin
        dsh   <= '0;
        rhold <= '0;
        sd1_o <= 1'b0;
      end else if (fall) begin
        dsh   <= ok ? rd_word[2*DW-1:DW] : '0;
        rhold <= ok ? rd_word[DW-1:0]    : '0;
        sd1_o <= 1'b0;
      end else if (rise) begin
        dsh   <= rhold;
        sd1_o <= 1'b0;
      end else begin
        sd1_o <= dsh[DW-1];
        dsh   <= dsh << 1;
      end
    end
  end

  logic mute_q;
  always_ff @(posedge bclk_i or negedge rst_n) begin
    if (!rst_n)    mute_q <= 1'b0;
    else if (fall) mute_q <= !ok;
  end

  assert_ws_follow_R4: assert property (@(posedge bclk_i) disable iff (!rst_n)
    $past(rst_n) |-> ws_o == $past(ws_i));

  assert_direct_follow_R5: assert property (@(posedge bclk_i) disable iff (!rst_n)
    $past(rst_n) |-> sd0_o == $past(sd_i));

  assert_pad_zero_R7: assert property (@(posedge bclk_i) disable iff (!rst_n)
    (!wse && cnt >= CW'(DW)) |=> !sd1_o);

  assert_mute_silent_R8: assert property (@(posedge bclk_i) disable iff (!rst_n)
    mute_q |-> !sd1_o);
endmodule

// File: tb/sim_i2s_delay_line.sv
module sim_i2s_delay_line;
  logic clk = 1'b0, rst_n = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [2:0] rate = 3'd0;
  logic [7:0] dly = 8'd50;
  logic ws_o, sd0_o, sd1_o;

  always #2 clk = ~clk;

  i2s_delay_line u0 (
    .bclk_i(clk), .rst_n(rst_n), .ws_i(ws), .sd_i(sd),
    .rate_sel(rate), .delay_us(dly),
    .ws_o(ws_o), .sd0_o(sd0_o), .sd1_o(sd1_o)
  );

  localparam int MAXF = 700;
  localparam int NSEG = 9;
  localparam int SEGF = 70;

  int checks = 0, errors = 0;
  logic [23:0] inL [MAXF], inR [MAXF], o0L [MAXF], o0R [MAXF], o1L [MAXF], o1R [MAXF];
  int nf [MAXF], seg0 [MAXF];
  bit skipL [MAXF];
  string tagf [MAXF];
  int seg_rate [NSEG], seg_dly [NSEG];
  string seg_tag [NSEG];

  function automatic int calc(int r, int d);
    int fs, q;
    case (r)
      0: fs = 441;  1: fs = 480;  2: fs = 882;
      3: fs = 960;  4: fs = 1764; 5: fs = 1920;
      default: fs = 480;
    endcase
    q = (d * fs + 5000) / 10000;
    if (q < 1) q = 1;
    if (q > 64) q = 64;
    return q;
  endfunction

  task automatic chk(input bit good, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_slot(input logic w, input logic [23:0] d, input bit do_chg,
                            input logic [2:0] nr, input logic [7:0] nd);
    for (int j = 0; j < 32; j++) begin
      @(negedge clk);
      ws = w;
      sd = (j >= 1 && j <= 24) ? d[24-j] : 1'b0;
      if (do_chg && j == 5) begin
        rate = nr;
        dly  = nd;
      end
    end
  endtask

  int mf = -1, mj = 0, r45_err = 0, pad_err = 0;
  logic pwo = 1'b0;
  logic [23:0] a0 = '0, a1 = '0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (ws_o !== ws || sd0_o !== sd) r45_err++;
      if (ws_o != pwo) begin
        mj = 0;
        if (!ws_o) mf++;
      end else mj++;
      pwo = ws_o;
      if (mj >= 1 && mj <= 24) begin
        a0 = {a0[22:0], sd0_o};
        a1 = {a1[22:0], sd1_o};
      end else if (sd1_o !== 1'b0) pad_err++;
      if (mj == 24 && mf >= 0 && mf < MAXF) begin
        if (!ws_o) begin o0L[mf] = a0; o1L[mf] = a1; end
        else       begin o0R[mf] = a0; o1R[mf] = a1; end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    int fidx;
    void'($urandom(32'd1234));
    seg_rate[0] = 0; seg_dly[0] = 50;  seg_tag[0] = "R2";
    seg_rate[1] = 3; seg_dly[1] = 100; seg_tag[1] = "R2";
    seg_rate[2] = 5; seg_dly[2] = 250; seg_tag[2] = "R2";
    seg_rate[3] = 1; seg_dly[3] = 0;   seg_tag[3] = "R9";
    seg_rate[4] = 2; seg_dly[4] = 177; seg_tag[4] = "R2";
    seg_rate[5] = 6; seg_dly[5] = 100; seg_tag[5] = "R2";
    seg_rate[6] = 4; seg_dly[6] = 250; seg_tag[6] = "R2";
    for (int i = 7; i < NSEG; i++) begin
      seg_rate[i] = int'($urandom % 6);
      seg_dly[i]  = 50 + int'($urandom % 201);
      seg_tag[i]  = "R2";
    end

    rate = 3'(seg_rate[0]);
    dly  = 8'(seg_dly[0]);
    ws = 1'b1; sd = 1'b1;
    repeat (5) @(negedge clk);
    chk(ws_o === 1'b0 && sd0_o === 1'b0 && sd1_o === 1'b0, "R1 reset outputs",
        {21'd0, ws_o, sd0_o, sd1_o}, 24'd0);
    ws = 1'b0; sd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive_slot(1'b1, 24'd0, 1'b0, 3'd0, 8'd0);

    fidx = 0;
    for (int sg = 0; sg < NSEG; sg++) begin
      for (int k = 0; k < SEGF; k++) begin
        bit dc;
        dc = (k == 0) && (sg > 0);
        inL[fidx]   = 24'($urandom);
        inR[fidx]   = 24'($urandom);
        nf[fidx]    = calc(seg_rate[sg], seg_dly[sg]);
        seg0[fidx]  = fidx - k;
        skipL[fidx] = dc;
        tagf[fidx]  = seg_tag[sg];
        drive_slot(1'b0, inL[fidx], dc, 3'(seg_rate[sg]), 8'(seg_dly[sg]));
        drive_slot(1'b1, inR[fidx], 1'b0, 3'd0, 8'd0);
        fidx++;
      end
    end
    drive_slot(1'b0, 24'd0, 1'b0, 3'd0, 8'd0);
    repeat (4) @(negedge clk);

    for (int m = 0; m < fidx; m++) begin
      int n;
      bit live;
      logic [23:0] eL, eR;
      n = nf[m];
      live = (m - n) >= seg0[m];
      eL = live ? inL[m-n] : 24'd0;
      eR = live ? inR[m-n] : 24'd0;
      chk(o0L[m] === inL[m], $sformatf("R5 direct left frame %0d", m), o0L[m], inL[m]);
      chk(o0R[m] === inR[m], $sformatf("R5 direct right frame %0d", m), o0R[m], inR[m]);
      if (!skipL[m])
        chk(o1L[m] === eL, $sformatf("%s %s delayed left frame %0d N=%0d",
            live ? "R3" : "R8", tagf[m], m, n), o1L[m], eL);
      chk(o1R[m] === eR, $sformatf("R6 %s %s delayed right frame %0d N=%0d",
          live ? "R3" : "R8", tagf[m], m, n), o1R[m], eR);
    end

    chk(r45_err == 0, "R4 R5 one-cycle retiming", 24'(r45_err), 24'd0);
    chk(pad_err == 0, "R7 delayed padding bits", 24'(pad_err), 24'd0);
    finish_run();
  end
endmodule